// File: doc/BRIEF.md
# Two-Write Four-Read Register File Built from Single-Port Banks

This block is the integer register file of a dual-issue pipeline. It accepts up to two writes and serves four reads in each clock cycle. The only storage primitive it uses is a simple memory with one write port and one read port.

Each write port owns one bank per read port, so there are eight banks in total. Every write goes to all banks of its port's group. A small side table holds one entry per register and records which write port stored the most recent value. Each read port reads the same address in its bank of every group, and the table entry for that address picks which bank's word is returned. The table costs one bit per register, which keeps the scheme far cheaper than a full flip-flop array with a crossbar.

Reads are synchronous. The data for an address presented in cycle t appears in cycle t+1. Register 0 is hard-wired to zero. The pipeline handles forwarding, so a write does not bypass to a read of the same address in the same cycle.

Top module: `lvt_regfile`

## Requirements
- R1: Each of the four read ports returns, on `rd_data[r]`, the contents of the register addressed by `rd_addr[r]` one clock edge earlier. All four ports work at once and on any mix of addresses.
- R2: A write accepted at one edge is returned by any read port whose address is sampled at a later edge.
- R3: A read sampled at the same edge as a write to the same register returns the value held before that write.
- R4: When both write ports are enabled for the same register at the same edge, the value from write port 1 is the one stored.
- R5: When the two write ports are enabled for different registers at the same edge, both values are stored.
- R6: Reading register 0 always returns zero. A write to register 0 from either port is dropped.
- R7: A write port whose `wr_en` bit is low leaves every register unchanged.
- R8: While `rst` is high and after its release, all `rd_data` outputs are zero until the first read is sampled.
- R9: The most recent write wins whichever port made it. A write by port 0 after an earlier write by port 1 to the same register is returned from then on.
- R10: A register that no enabled write targets keeps its value. Repeated reads of it return the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 2 | Write enable, bit w for write port w |
| wr_addr | input | 2x5 | Register index for each write port |
| wr_data | input | 2x32 | Write word for each write port |
| rd_addr | input | 4x5 | Register index for each read port |
| rd_data | output | 4x32 | Read word for each read port, one cycle after its address |

## Verification
The bench presents reads at the same edge as writes to the same register. A design that bypassed writes, or that updated the table before the bank read, would return the new word one cycle early. It drives both write ports at one register and expects port 1's word; a reversed priority in the table would return port 0's word. It hands a register back and forth between the ports and expects the latest word each time; a stale table entry would select the older bank. It also writes register 0 from both ports; a missing write gate or zero override would make register 0 read back non-zero.

// File: rtl/lvt_rf_pkg.sv
package lvt_rf_pkg;

  localparam int unsigned DEF_NUM_REGS = 32;
  localparam int unsigned DEF_DATA_W   = 32;
  localparam int unsigned DEF_NUM_WR   = 2;
  localparam int unsigned DEF_NUM_RD   = 4;

  // Width of a table entry that names one of n write ports.
  function automatic int unsigned sel_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Storage: no reset, as for a plain SRAM macro.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read register: sees the contents from before this edge's write.
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end

endmodule

// File: rtl/rf_lvt.sv
module rf_lvt #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned NUM_WR = 2,
  parameter int unsigned NUM_RD = 4,
  parameter int unsigned SEL_W  = 1,
  localparam int unsigned ADDR_W = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_WR-1:0]              we,
  input  logic [NUM_WR-1:0][ADDR_W-1:0]  waddr,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  raddr,
  output logic [NUM_RD-1:0][SEL_W-1:0]   rsel
);

  logic [SEL_W-1:0] owner_q [DEPTH];

  // Ports are visited in ascending order, so the highest-numbered
  // enabled port has the last nonblocking assignment and wins.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(DEPTH); i++) owner_q[i] <= '0;
    end else begin
      for (int w = 0; w < int'(NUM_WR); w++) begin
        if (we[w]) owner_q[waddr[w]] <= SEL_W'(w);
      end
    end
  end

  // Registered lookup, aligned with the bank read registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsel <= '0;
    end else begin
      for (int r = 0; r < int'(NUM_RD); r++) rsel[r] <= owner_q[raddr[r]];
    end
  end

endmodule

// File: rtl/rf_read_sel.sv
module rf_read_sel #(
  parameter int unsigned NUM_WR = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SEL_W  = 1
) (
  input  logic [NUM_WR-1:0][DATA_W-1:0] cand,
  input  logic [SEL_W-1:0]              sel,
  input  logic                          force_zero,
  output logic [DATA_W-1:0]             dout
);

  function automatic logic [DATA_W-1:0] pick(
    input logic [NUM_WR-1:0][DATA_W-1:0] c,
    input logic [SEL_W-1:0]              s,
    input logic                          z
  );
    logic [DATA_W-1:0] v;
    v = '0;
    if (!z) begin
      for (int w = 0; w < int'(NUM_WR); w++) begin
        if (SEL_W'(w) == s) v = c[w];
      end
    end
    return v;
  endfunction

  assign dout = pick(cand, sel, force_zero);

endmodule

// File: rtl/lvt_regfile.sv
module lvt_regfile
  import lvt_rf_pkg::*;
#(
  parameter int unsigned NUM_REGS = DEF_NUM_REGS,
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NUM_WR   = DEF_NUM_WR,
  parameter int unsigned NUM_RD   = DEF_NUM_RD,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS),
  localparam int unsigned SEL_W   = sel_width(NUM_WR)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_WR-1:0]             wr_en,
  input  logic [NUM_WR-1:0][ADDR_W-1:0] wr_addr,
  input  logic [NUM_WR-1:0][DATA_W-1:0] wr_data,
  input  logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr,
  output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);

  // Register 0 is never written.
  function automatic logic write_allowed(input logic en, input logic [ADDR_W-1:0] a);
    return en && (a != '0);
  endfunction

  // Named internal events for the checker.
  logic [NUM_WR-1:0]                    wr_eff;
  logic [NUM_RD-1:0][NUM_WR-1:0][DATA_W-1:0] bank_q;
  logic [NUM_RD-1:0][SEL_W-1:0]         lvt_sel;
  logic [NUM_RD-1:0]                    rd_zero_q;

  for (genvar w = 0; w < NUM_WR; w++) begin : g_wgate
    assign wr_eff[w] = write_allowed(wr_en[w], wr_addr[w]);
  end

  // One bank for every (write port, read port) pair.
  for (genvar w = 0; w < NUM_WR; w++) begin : g_grp
    for (genvar r = 0; r < NUM_RD; r++) begin : g_bank
      rf_bank #(
        .DEPTH (NUM_REGS),
        .DATA_W(DATA_W)
      ) u_bank (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_eff[w]),
        .waddr(wr_addr[w]),
        .wdata(wr_data[w]),
        .raddr(rd_addr[r]),
        .rdata(bank_q[r][w])
      );
    end
  end

  rf_lvt #(
    .DEPTH (NUM_REGS),
    .NUM_WR(NUM_WR),
    .NUM_RD(NUM_RD),
    .SEL_W (SEL_W)
  ) u_lvt (
    .clk  (clk),
    .rst  (rst),
    .we   (wr_eff),
    .waddr(wr_addr),
    .raddr(rd_addr),
    .rsel (lvt_sel)
  );

  // Register-0 flag, aligned with the read data; reset forces zero output.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_zero_q <= '1;
    end else begin
      for (int r = 0; r < int'(NUM_RD); r++) rd_zero_q[r] <= (rd_addr[r] == '0);
    end
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
    rf_read_sel #(
      .NUM_WR(NUM_WR),
      .DATA_W(DATA_W),
      .SEL_W (SEL_W)
    ) u_sel (
      .cand      (bank_q[r]),
      .sel       (lvt_sel[r]),
      .force_zero(rd_zero_q[r]),
      .dout      (rd_data[r])
    );
  end

endmodule

// File: rtl/lvt_rf_chk.sv
module lvt_rf_chk #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_WR   = 2,
  parameter int unsigned NUM_RD   = 4,
  localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
  input logic                          clk,
  input logic                          rst,
  input logic [NUM_WR-1:0]             wr_en,
  input logic [NUM_WR-1:0][ADDR_W-1:0] wr_addr,
  input logic [NUM_WR-1:0][DATA_W-1:0] wr_data,
  input logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr,
  input logic [NUM_RD-1:0][DATA_W-1:0] rd_data,
  input logic [NUM_WR-1:0]             wr_eff
);

  logic [1:0]                    cyc;
  logic [NUM_WR-1:0]             overr;
  logic [NUM_RD-1:0]             touch, touch_q;
  logic [NUM_RD-1:0][ADDR_W-1:0] rd_addr_q;

  always_ff @(posedge clk) begin
    if (rst) cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  // A port's write is shadowed if a higher port writes the same register.
  always_comb begin
    for (int w = 0; w < int'(NUM_WR); w++) begin
      overr[w] = 1'b0;
      for (int v = w + 1; v < int'(NUM_WR); v++) begin
        if (wr_eff[v] && wr_addr[v] == wr_addr[w]) overr[w] = 1'b1;
      end
    end
  end

  always_comb begin
    for (int r = 0; r < int'(NUM_RD); r++) begin
      touch[r] = 1'b0;
      for (int w = 0; w < int'(NUM_WR); w++) begin
        if (wr_eff[w] && wr_addr[w] == rd_addr[r]) touch[r] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      touch_q   <= '0;
      rd_addr_q <= '0;
    end else begin
      touch_q   <= touch;
      rd_addr_q <= rd_addr;
    end
  end

  for (genvar w = 0; w < NUM_WR; w++) begin : g_w
    // R6
    x0_write_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en[w] && wr_addr[w] == '0) |-> !wr_eff[w]);
  end

  for (genvar r = 0; r < NUM_RD; r++) begin : g_r
    // R6
    x0_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc != 2'd0 && $past(rd_addr[r]) == '0) |-> rd_data[r] == '0);

    // R10
    hold_value_chk: assert property (@(posedge clk) disable iff (rst)
      (cyc != 2'd0 && rd_addr[r] == rd_addr_q[r] && !touch_q[r]) |=> $stable(rd_data[r]));

    for (genvar w = 0; w < NUM_WR; w++) begin : g_rw
      // R2 R4: the newest unshadowed write is read back.
      write_readback_chk: assert property (@(posedge clk) disable iff (rst)
        (cyc >= 2'd2 && $past(wr_eff[w], 2) && !$past(overr[w], 2)
         && $past(rd_addr[r]) == $past(wr_addr[w], 2))
        |-> rd_data[r] == $past(wr_data[w], 2));
    end
  end

endmodule

bind lvt_regfile lvt_rf_chk #(
  .NUM_REGS(NUM_REGS),
  .DATA_W  (DATA_W),
  .NUM_WR  (NUM_WR),
  .NUM_RD  (NUM_RD)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data),
  .rd_addr(rd_addr),
  .rd_data(rd_data),
  .wr_eff (wr_eff)
);

// File: tb/tb_lvt_regfile.sv
`timescale 1ns/1ps
module tb_lvt_regfile;

  logic             clk = 1'b0;
  logic             rst;
  logic [1:0]       wr_en;
  logic [1:0][4:0]  wr_addr;
  logic [1:0][31:0] wr_data;
  logic [3:0][4:0]  rd_addr;
  logic [3:0][31:0] rd_data;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] model [32];
  bit          known [32];

  always #2.5 clk = ~clk;

  lvt_regfile dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // One clock: writes and reads are applied together. Expected read words
  // come from the model before this cycle's writes, then writes update it
  // in port order so port 1 lands last.
  task automatic cycle(input string tag,
                       input bit e0, input int a0, input logic [31:0] d0,
                       input bit e1, input int a1, input logic [31:0] d1,
                       input int r0, input int r1, input int r2, input int r3);
    int          ra [4];
    logic [31:0] exp [4];
    bit          chk_on [4];
    ra[0] = r0; ra[1] = r1; ra[2] = r2; ra[3] = r3;
    @(negedge clk);
    wr_en      = {e1, e0};
    wr_addr[0] = 5'(a0); wr_addr[1] = 5'(a1);
    wr_data[0] = d0;     wr_data[1] = d1;
    for (int r = 0; r < 4; r++) begin
      rd_addr[r] = 5'(ra[r]);
      exp[r]     = (ra[r] == 0) ? 32'h0 : model[ra[r]];
      chk_on[r]  = (ra[r] == 0) || known[ra[r]];
    end
    @(posedge clk);
    #1;
    for (int r = 0; r < 4; r++) begin
      if (chk_on[r]) chk($sformatf("%s port%0d reg%0d", tag, r, ra[r]), rd_data[r], exp[r]);
    end
    if (e0 && a0 != 0) begin model[a0] = d0; known[a0] = 1'b1; end
    if (e1 && a1 != 0) begin model[a1] = d1; known[a1] = 1'b1; end
    wr_en = 2'b00;
  endtask

  task automatic t_reset();
    rst = 1'b1; wr_en = '0; wr_addr = '0; wr_data = '0;
    rd_addr = {5'd3, 5'd2, 5'd1, 5'd9};
    repeat (3) @(posedge clk);
    #1;
    for (int r = 0; r < 4; r++) chk($sformatf("R8 reset port%0d", r), rd_data[r], 32'h0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    for (int r = 0; r < 4; r++) chk($sformatf("R8 after release port%0d", r), rd_data[r], 32'h0);
  endtask

  task automatic t_dual_write();
    cycle("R5 dual write", 1, 1, 32'hAAAA_0001, 1, 2, 32'hBBBB_0002, 0, 0, 0, 0);
    cycle("R2 R1 readback", 0, 0, 0, 0, 0, 0, 1, 2, 2, 1);
    cycle("R1 mixed ports", 1, 4, 32'h4444_4444, 1, 5, 32'h5555_5555, 2, 1, 0, 1);
    cycle("R1 four regs", 0, 0, 0, 0, 0, 0, 4, 5, 1, 2);
  endtask

  task automatic t_read_during_write();
    cycle("R3 setup", 1, 3, 32'hC0C0_C0C0, 0, 0, 0, 0, 0, 0, 0);
    cycle("R3 old value", 0, 0, 0, 1, 3, 32'hD0D0_D0D0, 3, 3, 3, 3);
    cycle("R3 new value", 1, 3, 32'hE0E0_E0E0, 0, 0, 0, 3, 3, 3, 3);
    cycle("R3 port0 write", 0, 0, 0, 0, 0, 0, 3, 3, 3, 3);
  endtask

  task automatic t_collision();
    cycle("R4 collide", 1, 7, 32'h0000_00E0, 1, 7, 32'h0000_00F1, 0, 0, 0, 0);
    cycle("R4 port1 wins", 0, 0, 0, 0, 0, 0, 7, 7, 7, 7);
    cycle("R4 collide again", 1, 9, 32'h1234_5678, 1, 9, 32'h8765_4321, 7, 0, 0, 0);
    cycle("R4 port1 wins 2", 0, 0, 0, 0, 0, 0, 9, 9, 9, 9);
  endtask

  task automatic t_owner_switch();
    cycle("R9 port1 first", 0, 0, 0, 1, 8, 32'h6666_0001, 0, 0, 0, 0);
    cycle("R9 port0 later", 1, 8, 32'h7777_0002, 0, 0, 0, 8, 8, 8, 8);
    cycle("R9 newest", 0, 0, 0, 1, 8, 32'h8888_0003, 8, 8, 8, 8);
    cycle("R9 back to port1", 0, 0, 0, 0, 0, 0, 8, 8, 8, 8);
  endtask

  task automatic t_x0();
    cycle("R6 write x0", 1, 0, 32'hDEAD_BEEF, 1, 0, 32'hFEED_F00D, 0, 0, 0, 0);
    cycle("R6 x0 reads zero", 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    cycle("R6 x0 and neighbour", 1, 0, 32'h1111_1111, 0, 0, 0, 0, 1, 0, 1);
  endtask

  task automatic t_disabled();
    cycle("R7 seed", 1, 10, 32'hAAAA_5555, 0, 0, 0, 0, 0, 0, 0);
    cycle("R7 disabled writes", 0, 10, 32'h0BAD_0BAD, 0, 10, 32'h0BAD_0BAD, 10, 0, 0, 0);
    cycle("R7 unchanged", 0, 0, 0, 0, 0, 0, 10, 10, 10, 10);
  endtask

  task automatic t_hold();
    for (int i = 0; i < 4; i++) begin
      cycle("R10 hold", 1, 12, 32'hF0F0_0000 + 32'(i), 0, 0, 0, 1, 2, 4, 5);
    end
    cycle("R10 hold final", 0, 0, 0, 0, 0, 0, 12, 1, 2, 10);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin model[i] = '0; known[i] = 1'b0; end
    t_reset();
    t_dual_write();
    t_read_during_write();
    t_collision();
    t_owner_switch();
    t_x0();
    t_disabled();
    t_hold();
    repeat (2) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule